// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block sits on the host side of a 12-bit sampling converter with a serial output. When asked, it pulls an active-low convert strobe low, waits a programmable time for the conversion to finish, and then drives 16 serial clock cycles. The converter shifts out a fixed frame on those clocks: three zero bits, the twelve result bits with the MSB first, and one closing zero. The controller samples the data line and checks the four zero bits. It returns the 12-bit value together with a single-cycle valid pulse and a framing-error flag.

The serial clock idles low and runs at the system clock divided by twice a programmable half-period. The 16 clocks go out either as one continuous burst or as two 8-clock bursts with an idle gap between them. In both cases the controller reassembles the result from all 16 samples. Sampling is on the rising serial edge that follows each data change, or on the falling edge inside the bit, as a phase setting selects. A continuous mode starts each new conversion as soon as the previous result has been acknowledged. A power-down input keeps the strobe parked high.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: After reset the strobe is high, the serial clock is low, and busy and valid are both low.
- R2: A start request in idle with power-down low drives the strobe low on the next clock. The strobe stays low for exactly 2*h system cycles, where h is the half-period setting. Busy rises in the same cycle as the strobe falls.
- R3: The first serial clock rising edge comes exactly W+h system cycles after the strobe returns high, where W is the wait setting.
- R4: Each frame has exactly 16 rising edges on the serial clock. The serial clock period is 2*h system cycles.
- R5: With phase 0, every bit is sampled on the rising edge that follows it. Frame bits 12 down to 1 (bit 15 is the first bit out) are returned as the result, with bit 12 as the result MSB.
- R6: With phase 1, the first bit is sampled on the first rising edge and the remaining bits on the falling edges. The result is the same as in R5.
- R7: With split high, the rising edges 8 and 9 are 2*h+G system cycles apart, where G is the burst gap parameter (default 3). Without split they are 2*h apart. The result is the same either way.
- R8: The framing error output is high with valid exactly when frame bit 15, 14, 13 or 0 reads as 1.
- R9: Valid is high for exactly one cycle. Busy stays high through that cycle and is low on the next one when no new conversion follows.
- R10: A start request is ignored while busy is high, including the valid cycle. No extra strobe falls.
- R11: While power-down is high and the block is idle, start requests are ignored and the strobe stays high.
- R12: In continuous mode, after valid the next strobe falls on the clock after acknowledge is seen, and never before that. An acknowledge given during the valid cycle itself counts. When continuous mode is cleared, the block returns to idle.
- R13: A half-period setting of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request |
| cont_i | input | 1 | Continuous conversion mode |
| ack_i | input | 1 | Result taken (continuous mode) |
| pdn_i | input | 1 | Power-down: keep strobe high, refuse requests |
| split_i | input | 1 | Issue frame as two 8-clock bursts |
| phase_i | input | 1 | Sample edge select (0 next rising, 1 falling) |
| div_i | input | DIV_W | Serial clock half-period in system cycles |
| wait_i | input | WAIT_W | Conversion wait in system cycles |
| sdo_i | input | 1 | Serial data from the converter |
| cnvst_n_o | output | 1 | Active-low convert strobe |
| sclk_o | output | 1 | Serial clock, idles low |
| result_o | output | 12 | Captured conversion result |
| valid_o | output | 1 | One-cycle result strobe |
| frm_err_o | output | 1 | A zero framing bit read as 1 |
| busy_o | output | 1 | Conversion in progress |

## Verification
Two functions can coincide in the cycle that carries valid: the end of one frame, and the request that opens the next one. In continuous mode the bench raises acknowledge in that cycle and expects the strobe to fall on the very next clock, with valid already low. In single mode it raises start in that same cycle and expects no new strobe, with busy dropping as usual.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int FRAME_W = 16;
    localparam int DATA_W  = 12;
    localparam int LEAD_Z  = 3;
    localparam int BURST_W = FRAME_W / 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_STRB  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_SHIFT = 3'd3,
        ST_GAP   = 3'd4,
        ST_DONE  = 3'd5,
        ST_HOLD  = 3'd6
    } ctl_st_e;

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } sg_t;

    sg_t  sg_q, sg_d;
    logic wrap;

    always_comb begin
        sg_d = sg_q;
        wrap = run_i && (sg_q.cnt == (half_i - 1'b1));
        if (!run_i) begin
            sg_d.cnt  = '0;
            sg_d.sclk = 1'b0;
        end else if (wrap) begin
            sg_d.cnt  = '0;
            sg_d.sclk = ~sg_q.sclk;
        end else begin
            sg_d.cnt = sg_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sg_q <= '0;
        else        sg_q <= sg_d;
    end

    assign sclk_o = sg_q.sclk;
    assign rise_o = wrap && !sg_q.sclk;
    assign fall_o = wrap &&  sg_q.sclk;

    // R4
    sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sclk_o);

endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift
    import adc_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              smp_i,
    input  logic              sdo_i,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o,
    output logic [CNT_W-1:0]  cnt_o
);

    typedef struct packed {
        logic [FRAME_W-1:0] word;
        logic [CNT_W-1:0]   cnt;
    } fs_t;

    fs_t fs_q, fs_d;

    always_comb begin
        fs_d = fs_q;
        if (clr_i) begin
            fs_d.word = '0;
            fs_d.cnt  = '0;
        end else if (smp_i && (fs_q.cnt < CNT_W'(FRAME_W))) begin
            fs_d.word = {fs_q.word[FRAME_W-2:0], sdo_i};
            fs_d.cnt  = fs_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign data_o = fs_q.word[FRAME_W-LEAD_Z-1 -: DATA_W];
    assign err_o  = (|fs_q.word[FRAME_W-1 -: LEAD_Z]) | fs_q.word[0];
    assign cnt_o  = fs_q.cnt;

    // R4
    smp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_i && !clr_i) |-> (fs_q.cnt < CNT_W'(FRAME_W)));

endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DIV_W   = 4,
    parameter int WAIT_W  = 6,
    parameter int GAP_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic              ack_i,
    input  logic              pdn_i,
    input  logic              split_i,
    input  logic              phase_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic              sdo_i,
    output logic              cnvst_n_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              frm_err_o,
    output logic              busy_o
);

    localparam int GAP_W  = $clog2(GAP_CYC + 1);
    localparam int STRB_W = DIV_W + 1;
    localparam int TMR_A  = (STRB_W > WAIT_W) ? STRB_W : WAIT_W;
    localparam int TMR_W  = (TMR_A > GAP_W) ? TMR_A : GAP_W;

    typedef struct packed {
        logic [DIV_W-1:0]  half;
        logic [WAIT_W-1:0] wt;
        logic              split;
        logic              phase;
    } cfg_t;

    typedef struct packed {
        ctl_st_e          st;
        logic [TMR_W-1:0] tmr;
        logic [CNT_W-1:0] falls;
        cfg_t             cfg;
    } ctl_t;

    ctl_t             ctl_q, ctl_d;
    cfg_t             cfg_in;
    logic             relaunch;
    logic             sg_run, sg_rise, sg_fall, smp;
    logic [CNT_W-1:0] nsmp;
    logic [TMR_W-1:0] strb_last, wait_last, gap_last;

    always_comb begin
        cfg_in.half  = (div_i == '0) ? DIV_W'(1) : div_i;
        cfg_in.wt    = wait_i;
        cfg_in.split = split_i;
        cfg_in.phase = phase_i;
    end

    assign strb_last = TMR_W'({ctl_q.cfg.half, 1'b0}) - TMR_W'(1);
    assign wait_last = TMR_W'(ctl_q.cfg.wt) - TMR_W'(1);
    assign gap_last  = TMR_W'(GAP_CYC - 1);

    always_comb begin
        ctl_d    = ctl_q;
        relaunch = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start_i && !pdn_i) relaunch = 1'b1;
            end
            ST_STRB: begin
                ctl_d.tmr = ctl_q.tmr + 1'b1;
                if (ctl_q.tmr == strb_last) begin
                    ctl_d.tmr = '0;
                    ctl_d.st  = (ctl_q.cfg.wt == '0) ? ST_SHIFT : ST_WAIT;
                end
            end
            ST_WAIT: begin
                ctl_d.tmr = ctl_q.tmr + 1'b1;
                if (ctl_q.tmr == wait_last) begin
                    ctl_d.tmr = '0;
                    ctl_d.st  = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sg_fall) begin
                    ctl_d.falls = ctl_q.falls + 1'b1;
                    if (ctl_q.falls == CNT_W'(FRAME_W - 1)) begin
                        ctl_d.st = ST_DONE;
                    end else if (ctl_q.cfg.split &&
                                 (ctl_q.falls == CNT_W'(BURST_W - 1))) begin
                        ctl_d.st  = ST_GAP;
                        ctl_d.tmr = '0;
                    end
                end
            end
            ST_GAP: begin
                ctl_d.tmr = ctl_q.tmr + 1'b1;
                if (ctl_q.tmr == gap_last) begin
                    ctl_d.tmr = '0;
                    ctl_d.st  = ST_SHIFT;
                end
            end
            ST_DONE: begin
                if (cont_i && !pdn_i) begin
                    if (ack_i) relaunch = 1'b1;
                    else       ctl_d.st = ST_HOLD;
                end else begin
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (!cont_i || pdn_i) ctl_d.st = ST_IDLE;
                else if (ack_i)       relaunch = 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (relaunch) begin
            ctl_d.st    = ST_STRB;
            ctl_d.tmr   = '0;
            ctl_d.falls = '0;
            ctl_d.cfg   = cfg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sg_run = (ctl_q.st == ST_SHIFT);

    always_comb begin
        if (ctl_q.cfg.phase) begin
            smp = sg_run && ((sg_rise && (ctl_q.falls == '0)) ||
                             (sg_fall && (ctl_q.falls < CNT_W'(FRAME_W - 1))));
        end else begin
            smp = sg_run && sg_rise;
        end
    end

    adc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (sg_run),
        .half_i (ctl_q.cfg.half),
        .sclk_o (sclk_o),
        .rise_o (sg_rise),
        .fall_o (sg_fall)
    );

    adc_frame_shift u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (relaunch),
        .smp_i  (smp),
        .sdo_i  (sdo_i),
        .data_o (result_o),
        .err_o  (frm_err_o),
        .cnt_o  (nsmp)
    );

    assign cnvst_n_o = (ctl_q.st != ST_STRB);
    assign valid_o   = (ctl_q.st == ST_DONE);
    assign busy_o    = (ctl_q.st != ST_IDLE) && (ctl_q.st != ST_HOLD);

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> busy_o);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !valid_o) |=> busy_o);

    // R11
    pdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && pdn_i) |=> cnvst_n_o);

    // R2
    strb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnvst_n_o |-> !sclk_o);

    // R5
    full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (nsmp == CNT_W'(FRAME_W)));

    // R12
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_HOLD && !ack_i) |=> cnvst_n_o);

endmodule

// File: tb/adc_rdout_ctrl_bench.sv
module adc_rdout_ctrl_bench;

    localparam int PERIOD = 10;
    localparam int GAP    = 3;

    typedef struct packed {
        logic [15:0] frame;
        logic [3:0]  div;
        logic [5:0]  wt;
        logic        split;
        logic        phase;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{16'h14B8, 4'd1, 6'd2, 1'b0, 1'b0},
        '{16'h0000, 4'd2, 6'd0, 1'b0, 1'b1},
        '{16'h1FFE, 4'd3, 6'd5, 1'b1, 1'b0},
        '{16'h078E, 4'd1, 6'd1, 1'b1, 1'b1},
        '{16'h1002, 4'd0, 6'd3, 1'b0, 1'b0},
        '{16'h8246, 4'd2, 6'd1, 1'b0, 1'b0},
        '{16'h08AD, 4'd1, 6'd0, 1'b0, 1'b1},
        '{16'h2FCE, 4'd2, 6'd2, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, cont_i = 1'b0, ack_i = 1'b0, pdn_i = 1'b0;
    logic        split_i = 1'b0, phase_i = 1'b0;
    logic [3:0]  div_i = 4'd1;
    logic [5:0]  wait_i = 6'd0;
    logic        sdo_i = 1'b0;
    logic        cnvst_n_o, sclk_o, valid_o, frm_err_o, busy_o;
    logic [11:0] result_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    adc_rdout_ctrl #(.DIV_W(4), .WAIT_W(6), .GAP_CYC(GAP)) u_adc_rdout_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i), .ack_i(ack_i),
        .pdn_i(pdn_i), .split_i(split_i), .phase_i(phase_i), .div_i(div_i),
        .wait_i(wait_i), .sdo_i(sdo_i), .cnvst_n_o(cnvst_n_o), .sclk_o(sclk_o),
        .result_o(result_o), .valid_o(valid_o), .frm_err_o(frm_err_o), .busy_o(busy_o)
    );

    // converter model: first bit after strobe falls, next bit after each rising edge
    logic [15:0] cur_frame = 16'h0000;
    int          bidx = 0;
    always @(negedge cnvst_n_o) begin
        bidx = 15;
        sdo_i <= #1 cur_frame[15];
    end
    always @(posedge sclk_o) begin
        bidx = bidx - 1;
        sdo_i <= #1 (bidx >= 0) ? cur_frame[bidx[3:0]] : 1'b0;
    end

    // edge monitors
    int  rises = 0;
    int  cfalls = 0;
    time t_r [20];
    time t_cf = 0, t_cr = 0;
    always @(posedge sclk_o) begin
        if (rises < 20) t_r[rises] = $time;
        rises = rises + 1;
    end
    always @(negedge cnvst_n_o) begin
        cfalls = cfalls + 1;
        t_cf = $time;
    end
    always @(posedge cnvst_n_o) t_cr = $time;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_valid(output bit ok);
        int n = 0;
        ok = 1'b0;
        while (n < 4000) begin
            @(negedge clk);
            if (valid_o) begin
                ok = 1'b1;
                break;
            end
            n++;
        end
    endtask

    function automatic int cyc(input time a, input time b);
        return int'((a - b) / PERIOD);
    endfunction

    task automatic run_vec(input vec_t v);
        int h;
        bit ok;
        int exp_gap;
        logic [11:0] exp_data;
        logic exp_err;
        h = (v.div == 0) ? 1 : int'(v.div);
        exp_data = v.frame[12:1];
        exp_err  = v.frame[15] | v.frame[14] | v.frame[13] | v.frame[0];
        exp_gap  = v.split ? 2*h + GAP : 2*h;
        @(negedge clk);
        cur_frame = v.frame;
        div_i = v.div; wait_i = v.wt; split_i = v.split; phase_i = v.phase;
        rises = 0; cfalls = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!cnvst_n_o && busy_o, "R2", "strobe and busy on start",
            {30'd0, cnvst_n_o, busy_o}, 1);
        wait_valid(ok);
        chk(ok, "R9", "valid seen", int'(ok), 1);
        if (v.phase)
            chk(result_o == exp_data, "R6", "result", int'(result_o), int'(exp_data));
        else
            chk(result_o == exp_data, "R5", "result", int'(result_o), int'(exp_data));
        chk(frm_err_o == exp_err, "R8", "framing error", int'(frm_err_o), int'(exp_err));
        chk(rises == 16, "R4", "rising edges", rises, 16);
        chk(cyc(t_cr, t_cf) == 2*h, (v.div == 0) ? "R13" : "R2", "strobe width",
            cyc(t_cr, t_cf), 2*h);
        chk(cyc(t_r[0], t_cr) == int'(v.wt) + h, "R3", "first edge delay",
            cyc(t_r[0], t_cr), int'(v.wt) + h);
        chk(cyc(t_r[1], t_r[0]) == 2*h, "R4", "sclk period", cyc(t_r[1], t_r[0]), 2*h);
        chk(cyc(t_r[8], t_r[7]) == exp_gap, "R7", "edge 8 to 9", cyc(t_r[8], t_r[7]),
            exp_gap);
        @(negedge clk);
        chk(!valid_o && !busy_o, "R9", "valid and busy drop",
            {30'd0, valid_o, busy_o}, 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(cnvst_n_o && !sclk_o && !busy_o && !valid_o, "R1", "reset state",
            {28'd0, cnvst_n_o, sclk_o, busy_o, valid_o}, 8);

        for (int i = 0; i < 8; i++) run_vec(VECS[i]);

        // R10: requests during a frame and in the valid cycle
        cur_frame = 16'h0B52; div_i = 4'd1; wait_i = 6'd1; split_i = 1'b0; phase_i = 1'b0;
        @(negedge clk);
        cfalls = 0;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (6) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        wait_valid(ok);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(cnvst_n_o && !busy_o, "R10", "start in valid cycle ignored",
            {30'd0, cnvst_n_o, busy_o}, 2);
        repeat (30) @(negedge clk);
        chk(cfalls == 1, "R10", "strobe falls", cfalls, 1);

        // R11: power-down refuses requests
        pdn_i = 1'b1;
        cfalls = 0;
        start_i = 1'b1;
        repeat (5) @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        chk(cfalls == 0 && cnvst_n_o && !busy_o, "R11", "power-down strobe falls",
            cfalls, 0);
        pdn_i = 1'b0;

        // R12: continuous mode
        cur_frame = 16'h06B4; div_i = 4'd1; wait_i = 6'd1; cont_i = 1'b1;
        @(negedge clk);
        cfalls = 0;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        wait_valid(ok);
        chk(ok && result_o == 12'h35A, "R12", "first continuous result",
            int'(result_o), 12'h35A);
        repeat (20) @(negedge clk);
        chk(cfalls == 1 && cnvst_n_o && !busy_o, "R12", "no relaunch before ack",
            cfalls, 1);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        chk(!cnvst_n_o && busy_o, "R12", "relaunch after ack", int'(cnvst_n_o), 0);
        wait_valid(ok);
        chk(ok && result_o == 12'h35A, "R12", "second continuous result",
            int'(result_o), 12'h35A);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        chk(!cnvst_n_o && !valid_o, "R12", "ack in valid cycle relaunches",
            {30'd0, cnvst_n_o, valid_o}, 0);
        cont_i = 1'b0;
        wait_valid(ok);
        repeat (30) @(negedge clk);
        chk(cfalls == 3 && !busy_o && cnvst_n_o, "R12", "return to idle", cfalls, 3);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule